// File: doc/BRIEF.md
# DMA Read Tag and Completion Tracker

This block sits between a DMA engine and the transaction layer of a host link. The engine hands it read commands, each a start address and a byte length. The tracker cuts every command into read requests no longer than a configured maximum request size. It gives each request a tag from a finite pool and presents it on a request stream. Host memory then answers each request with one or more completions that carry the tag and a byte count. A long request comes back in pieces cut at a 64- or 128-byte boundary. Pieces of one request arrive in order. Pieces of different requests may interleave in any order.

For every tag the tracker keeps the number of bytes still owed and the time since the request was presented. A tag is released in one of two ways. If its last byte arrives, the tracker reports done with that tag. If its age reaches the programmed limit before that, the tracker reports a timeout error with that tag. Once a tag has timed out, any completion that still arrives for it is discarded. While every tag in the active pool is held, no new request is presented.

Both streams use valid/ready. The command stream accepts a command when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low until the previous command has been fully cut into requests. The request stream holds `req_tag`, `req_addr` and `req_len` unchanged while `req_valid` is high and `req_ready` is low. Completions are always accepted. Done and error reports are single-cycle pulses. The configuration inputs (`ext_tag_en`, `mrrs_sel`, `tmo_limit`) must be held steady while any request is outstanding.

Top module: `rdtag_tracker`

## Requirements
- R1: A tag stays held from the cycle its request is presented until the tag is released. While every tag in the active pool is held, `req_valid` stays low. A request waiting for a free tag is presented in the cycle after a tag is freed.
- R2: With `ext_tag_en`=0 the pool is tags 0 to 31. With `ext_tag_en`=1 the pool is tags 0 to 255. Each new request takes the lowest-numbered free tag in the pool.
- R3: `mrrs_sel`=n limits every request to 128·2^n bytes for n from 0 to 4. Values 5, 6 and 7 give a 4096-byte limit. A command is cut into full-limit requests followed by one shorter remainder. The requests carry consecutive addresses starting at the command address.
- R4: A request may be answered by several completions. The completion whose byte count reaches or passes the bytes still owed by its tag produces a `done_valid` pulse carrying that tag, one cycle after the completion was presented, and frees the tag. Earlier pieces produce no pulse.
- R5: Completions for different tags may be interleaved in any order. Each tag keeps its own byte count.
- R6: A tag whose age reaches `tmo_limit` cycles produces an `err_valid` pulse carrying that tag, exactly `tmo_limit`+1 cycles after its request was first presented, and the tag is freed. Partial completions do not restart the age.
- R7: A completion for a tag that is free or timed out is discarded and produces no done pulse.
- R8: While `req_valid` is high and `req_ready` is low, `req_tag`, `req_addr` and `req_len` are held. `cmd_ready` is low while a command is still being cut. A zero-length command is accepted and produces no request.
- R9: After reset `cmd_ready` is high, and `req_valid`, `done_valid` and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_tag_en | input | 1 | Selects the 256-tag pool instead of 32 |
| mrrs_sel | input | 3 | Maximum request size code, 128·2^n bytes, capped at 4096 |
| tmo_limit | input | 16 | Completion timeout in cycles |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_addr | input | 32 | Command start address |
| cmd_len | input | 16 | Command length in bytes |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Request taken this cycle |
| req_tag | output | 8 | Tag of the request |
| req_addr | output | 32 | Request address |
| req_len | output | 13 | Request length in bytes |
| cpl_valid | input | 1 | Completion piece present |
| cpl_tag | input | 8 | Tag the completion answers |
| cpl_bytes | input | 13 | Bytes carried by this piece |
| done_valid | output | 1 | Pulse: a tag received all its bytes |
| done_tag | output | 8 | Tag that finished |
| err_valid | output | 1 | Pulse: a tag timed out |
| err_tag | output | 8 | Tag that timed out |

## Verification
The hardest situation to reach from the ports is a full pool. Every tag must be held at once, so that a further request is stalled and then released by a single completion. The bench reaches it by issuing one command longer than the whole pool at the smallest request size, with no completions returned. It does this for both the 32-tag and the 256-tag pool. The timeout race is reached by answering only part of a request and then letting it age: the error must land on its exact cycle, and a later completion for that tag must be discarded.

// File: rtl/rdtag_pkg.sv
package rdtag_pkg;
  localparam int MAX_REQ_BYTES = 4096;
  localparam int REQ_LEN_W     = $clog2(MAX_REQ_BYTES) + 1;

  // request size limit for a 3-bit size code: 128 << n, capped at 4096
  function automatic logic [REQ_LEN_W-1:0] mrrs_bytes(input logic [2:0] code);
    if (code >= 3'd5) return REQ_LEN_W'(MAX_REQ_BYTES);
    return REQ_LEN_W'(128) << code;
  endfunction
endpackage

// File: rtl/free_tag_pick.sv
module free_tag_pick #(
  parameter int NTAG  = 256,
  parameter int BASIC = 32,
  parameter int TAG_W = $clog2(NTAG)
) (
  input  logic [NTAG-1:0]  busy,
  input  logic             ext_en,
  output logic             avail,
  output logic [TAG_W-1:0] tag
);
  always_comb begin
    avail = 1'b0;
    tag   = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy[i] && (ext_en || i < BASIC)) begin
        avail = 1'b1;
        tag   = TAG_W'(i);
      end
    end
  end

  always_comb begin
    assert_pool_limit_R2: assert (!avail || ext_en || int'(tag) < BASIC);
    assert_pick_free_R1: assert (!avail || !busy[tag]);
  end
endmodule

// File: rtl/rd_splitter.sv
module rd_splitter import rdtag_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int CMD_LEN_W = 16,
  parameter int TAG_W     = 8,
  parameter int LEN_W     = REQ_LEN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mrrs_sel,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [CMD_LEN_W-1:0] cmd_len,
  input  logic                 tag_avail,
  input  logic [TAG_W-1:0]     free_tag,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [TAG_W-1:0]     req_tag,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [LEN_W-1:0]     req_len,
  output logic                 alloc,
  output logic [TAG_W-1:0]     alloc_tag,
  output logic [LEN_W-1:0]     alloc_len
);
  logic                 active_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [CMD_LEN_W-1:0] left_q;
  logic [LEN_W-1:0]     lim, chunk;
  logic                 load;

  always_comb begin
    lim   = LEN_W'(mrrs_bytes(mrrs_sel));
    chunk = (left_q < CMD_LEN_W'(lim)) ? left_q[LEN_W-1:0] : lim;
  end

  assign cmd_ready = !active_q;
  assign load      = active_q && tag_avail && (!req_valid || req_ready);
  assign alloc     = load;
  assign alloc_tag = free_tag;
  assign alloc_len = chunk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      addr_q    <= '0;
      left_q    <= '0;
      req_valid <= 1'b0;
      req_tag   <= '0;
      req_addr  <= '0;
      req_len   <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        active_q <= (cmd_len != '0);
        addr_q   <= cmd_addr;
        left_q   <= cmd_len;
      end else if (load) begin
        addr_q <= addr_q + ADDR_W'(chunk);
        left_q <= left_q - CMD_LEN_W'(chunk);
        if (left_q == CMD_LEN_W'(chunk)) active_q <= 1'b0;
      end
      if (load) begin
        req_valid <= 1'b1;
        req_tag   <= free_tag;
        req_addr  <= addr_q;
        req_len   <= chunk;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  assert_req_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && req_len <= LEN_W'(mrrs_bytes(mrrs_sel))));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_tag) &&
                                   $stable(req_addr) && $stable(req_len)));
endmodule

// File: rtl/tag_ledger.sv
module tag_ledger #(
  parameter int NTAG  = 256,
  parameter int TAG_W = $clog2(NTAG),
  parameter int LEN_W = 13,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmo_limit,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [LEN_W-1:0] alloc_len,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [LEN_W-1:0] cpl_bytes,
  output logic [NTAG-1:0]  busy,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             err_valid,
  output logic [TAG_W-1:0] err_tag
);
  logic [LEN_W-1:0] remain [NTAG];
  logic [NTAG-1:0]  expired;
  logic             hit, finish, exp_any;
  logic [TAG_W-1:0] exp_tag;

  assign hit    = cpl_valid && busy[cpl_tag] && !expired[cpl_tag];
  assign finish = cpl_bytes >= remain[cpl_tag];

  always_comb begin
    exp_any = 1'b0;
    exp_tag = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (expired[i]) begin
        exp_any = 1'b1;
        exp_tag = TAG_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NTAG; g++) begin : g_tag
    logic             b_q;
    logic [LEN_W-1:0] r_q;
    logic [TMR_W-1:0] t_q;
    logic             mine_alloc, mine_cpl, mine_err;

    assign mine_alloc = alloc && (alloc_tag == TAG_W'(g));
    assign mine_cpl   = hit && (cpl_tag == TAG_W'(g));
    assign mine_err   = exp_any && (exp_tag == TAG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= 1'b0;
        r_q <= '0;
        t_q <= '0;
      end else if (mine_alloc) begin
        b_q <= 1'b1;
        r_q <= alloc_len;
        t_q <= '0;
      end else if (b_q) begin
        if (mine_cpl) begin
          if (finish) b_q <= 1'b0;
          else        r_q <= r_q - cpl_bytes;
        end else if (mine_err) begin
          b_q <= 1'b0;
        end
        if (t_q != '1) t_q <= t_q + 1'b1;
      end
    end

    assign busy[g]    = b_q;
    assign remain[g]  = r_q;
    assign expired[g] = b_q && (t_q >= tmo_limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      err_valid  <= 1'b0;
      err_tag    <= '0;
    end else begin
      done_valid <= hit && finish;
      done_tag   <= cpl_tag;
      err_valid  <= exp_any;
      err_tag    <= exp_tag;
    end
  end

  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy[alloc_tag]);

  assert_done_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy[done_tag]);

  assert_err_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !busy[err_tag]);

  assert_done_err_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && err_valid) |-> (done_tag != err_tag));
endmodule

// File: rtl/rdtag_tracker.sv
module rdtag_tracker import rdtag_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int CMD_LEN_W  = 16,
  parameter int MAX_TAGS   = 256,
  parameter int BASIC_TAGS = 32,
  parameter int TMR_W      = 16,
  localparam int TAG_W     = $clog2(MAX_TAGS),
  localparam int LEN_W     = REQ_LEN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_tag_en,
  input  logic [2:0]           mrrs_sel,
  input  logic [TMR_W-1:0]     tmo_limit,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [CMD_LEN_W-1:0] cmd_len,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [TAG_W-1:0]     req_tag,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [LEN_W-1:0]     req_len,
  input  logic                 cpl_valid,
  input  logic [TAG_W-1:0]     cpl_tag,
  input  logic [LEN_W-1:0]     cpl_bytes,
  output logic                 done_valid,
  output logic [TAG_W-1:0]     done_tag,
  output logic                 err_valid,
  output logic [TAG_W-1:0]     err_tag
);
  logic [MAX_TAGS-1:0] busy;
  logic                tag_avail, alloc;
  logic [TAG_W-1:0]    free_tag, alloc_tag;
  logic [LEN_W-1:0]    alloc_len;

  free_tag_pick #(.NTAG(MAX_TAGS), .BASIC(BASIC_TAGS), .TAG_W(TAG_W)) u_pick (
    .busy(busy), .ext_en(ext_tag_en), .avail(tag_avail), .tag(free_tag)
  );

  rd_splitter #(.ADDR_W(ADDR_W), .CMD_LEN_W(CMD_LEN_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_split (
    .clk(clk), .rst_n(rst_n), .mrrs_sel(mrrs_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .tag_avail(tag_avail), .free_tag(free_tag),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .req_addr(req_addr), .req_len(req_len),
    .alloc(alloc), .alloc_tag(alloc_tag), .alloc_len(alloc_len)
  );

  tag_ledger #(.NTAG(MAX_TAGS), .TAG_W(TAG_W), .LEN_W(LEN_W), .TMR_W(TMR_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .alloc(alloc), .alloc_tag(alloc_tag), .alloc_len(alloc_len),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
    .busy(busy),
    .done_valid(done_valid), .done_tag(done_tag),
    .err_valid(err_valid), .err_tag(err_tag)
  );
endmodule

// File: tb/rdtag_tracker_bench.sv
module rdtag_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tag_en = 1'b0;
  logic [2:0]  mrrs_sel = 3'd0;
  logic [15:0] tmo_limit = 16'd60000;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [7:0]  req_tag;
  logic [31:0] req_addr;
  logic [12:0] req_len;
  logic        cpl_valid = 1'b0;
  logic [7:0]  cpl_tag = '0;
  logic [12:0] cpl_bytes = '0;
  logic        done_valid;
  logic [7:0]  done_tag;
  logic        err_valid;
  logic [7:0]  err_tag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rdtag_tracker u_rdtag_tracker (
    .clk(clk), .rst_n(rst_n), .ext_tag_en(ext_tag_en), .mrrs_sel(mrrs_sel),
    .tmo_limit(tmo_limit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .req_valid(req_valid),
    .req_ready(req_ready), .req_tag(req_tag), .req_addr(req_addr),
    .req_len(req_len), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_bytes(cpl_bytes), .done_valid(done_valid), .done_tag(done_tag),
    .err_valid(err_valid), .err_tag(err_tag)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // offer a command; returns at the negedge after it was accepted
  task automatic issue_cmd(input logic [31:0] a, input int len);
    @(negedge clk);
    cmd_addr  = a;
    cmd_len   = 16'(len);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // drive one completion piece; check the done pulse one cycle later
  task automatic send_cpl(input int tag, input int bytes, input bit exp_done, input string r);
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_tag   = 8'(tag);
    cpl_bytes = 13'(bytes);
    @(negedge clk);
    cpl_valid = 1'b0;
    chk(done_valid == exp_done, r, done_valid, exp_done);
    if (exp_done) chk(done_tag == 8'(tag), r, done_tag, tag);
  endtask

  // R3 R4 R5: cut a command, then answer in reverse tag order, interleaved
  task automatic sweep(input int sel, input int len, input logic [31:0] base);
    int lim = (sel >= 5) ? 4096 : (128 << sel);
    int n   = (len + lim - 1) / lim;
    int rcb = (sel % 2 == 1) ? 128 : 64;
    int left [64];
    int got = 0;
    bool_any: begin end
    @(negedge clk);
    mrrs_sel = 3'(sel);
    issue_cmd(base, len);
    for (int c = 0; c < 200 && got < n; c++) begin
      if (req_valid) begin
        int exp_len = (got == n - 1) ? len - lim * (n - 1) : lim;
        chk(req_tag == 8'(got), "R2 lowest free tag", req_tag, got);
        chk(req_addr == base + 32'(got * lim), "R3 request address", req_addr, base + 32'(got * lim));
        chk(req_len == 13'(exp_len), "R3 request length", req_len, exp_len);
        left[got] = exp_len;
        got++;
      end
      @(negedge clk);
    end
    chk(got == n, "R3 request count", got, n);
    for (int round = 0; round < 80; round++) begin
      for (int i = n - 1; i >= 0; i--) begin
        if (left[i] > 0) begin
          int p = (left[i] < rcb) ? left[i] : rcb;
          left[i] -= p;
          send_cpl(i, p, left[i] == 0, "R4 R5 piecewise completion");
        end
      end
    end
    chk(cmd_ready == 1'b1, "R8 command side idle", cmd_ready, 1);
  endtask

  // R1 R2: fill the whole pool, stall, free one tag, then drain
  task automatic exhaust(input bit ext, input int pool);
    int got = 0;
    @(negedge clk);
    ext_tag_en = ext;
    mrrs_sel   = 3'd0;
    issue_cmd(32'h0010_0000, (pool + 1) * 128);
    for (int c = 0; c < pool + 50 && got < pool; c++) begin
      if (req_valid) begin
        chk(req_tag == 8'(got), "R2 pool tag order", req_tag, got);
        got++;
      end
      @(negedge clk);
    end
    chk(got == pool, "R2 pool size", got, pool);
    repeat (5) @(negedge clk);
    chk(req_valid == 1'b0, "R1 stall with pool full", req_valid, 0);
    chk(cmd_ready == 1'b0, "R8 command held while cutting", cmd_ready, 0);
    send_cpl(5, 128, 1'b1, "R4 single completion");
    @(negedge clk);
    chk(req_valid == 1'b1, "R1 request after free", req_valid, 1);
    chk(req_tag == 8'd5, "R1 freed tag reused", req_tag, 5);
    for (int t = 0; t < pool; t++) send_cpl(t, 128, 1'b1, "R4 drain");
    chk(cmd_ready == 1'b1, "R8 command side idle", cmd_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 reset cmd_ready", cmd_ready, 1);
    chk(req_valid == 1'b0, "R9 reset req_valid", req_valid, 0);
    chk(done_valid == 1'b0, "R9 reset done_valid", done_valid, 0);
    chk(err_valid == 1'b0, "R9 reset err_valid", err_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 sweep over size codes, including the capped ones
    for (int s = 0; s < 8; s++) begin
      sweep(s, 300, 32'h0000_1000 + 32'(s * 32'h1_0000));
      sweep(s, 1000, 32'h0800_0000 + 32'(s * 32'h1_0000));
    end
    sweep(6, 5000, 32'h2000_0000);
    sweep(7, 8192, 32'h3000_0000);

    // R8 zero-length command gives no request
    issue_cmd(32'h4000_0000, 0);
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R8 zero length", req_valid, 0);

    // R8 back-pressure holds the request
    @(negedge clk);
    req_ready = 1'b0;
    mrrs_sel  = 3'd0;
    issue_cmd(32'h5000_0000, 256);
    @(negedge clk);
    chk(req_valid == 1'b1, "R8 request offered", req_valid, 1);
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b1 && req_tag == 8'd0 && req_addr == 32'h5000_0000 && req_len == 13'd128,
        "R8 held under back-pressure", req_addr, 32'h5000_0000);
    req_ready = 1'b1;
    @(negedge clk);
    chk(req_tag == 8'd1 && req_addr == 32'h5000_0080, "R8 next after release", req_tag, 1);
    @(negedge clk);
    send_cpl(1, 128, 1'b1, "R5 out of order");
    send_cpl(0, 128, 1'b1, "R5 out of order");

    // R7 completion for a free tag is dropped
    send_cpl(9, 64, 1'b0, "R7 free tag dropped");

    exhaust(1'b0, 32);
    exhaust(1'b1, 256);
    @(negedge clk);
    ext_tag_en = 1'b0;

    // R6 timeout after a partial answer, then R7 late piece dropped
    tmo_limit = 16'd20;
    issue_cmd(32'h6000_0000, 64);
    begin
      int tag = -1;
      for (int c = 0; c < 10 && tag < 0; c++) begin
        if (req_valid) tag = int'(req_tag);
        else @(negedge clk);
      end
      chk(tag == 0, "R6 request presented", tag, 0);
      send_cpl(0, 32, 1'b0, "R4 partial no done");
      for (int k = 3; k <= 20; k++) begin
        @(negedge clk);
        if (k == 20) chk(err_valid == 1'b0, "R6 not before limit", err_valid, 0);
      end
      @(negedge clk);
      chk(err_valid == 1'b1, "R6 timeout pulse", err_valid, 1);
      chk(err_tag == 8'd0, "R6 timeout tag", err_tag, 0);
      @(negedge clk);
      chk(err_valid == 1'b0, "R6 single pulse", err_valid, 0);
      send_cpl(0, 32, 1'b0, "R7 late piece dropped");
    end
    issue_cmd(32'h7000_0000, 64);
    @(negedge clk);
    chk(req_valid == 1'b1 && req_tag == 8'd0, "R6 timed-out tag reusable", req_tag, 0);
    @(negedge clk);
    send_cpl(0, 64, 1'b1, "R4 reused tag completes");
    @(negedge clk);
    tmo_limit = 16'd60000;

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule